// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block produces the serial clock for an I2C bit engine in two stages. A prescaler divides the system clock down to an internal reference of about 10 MHz. Software programs the prescale value as the system clock in MHz divided by ten, rounded to the nearest integer. A second counter then runs in units of that reference. It holds SCL low for a programmed number of ticks and then high for a programmed number of ticks, and repeats.

The two half-period counts share one 16-bit divider word, with the high count in the upper byte and the low count in the lower byte. For a target rate in kHz, each half is (10000 / rate + 1) / 2 ticks. Over the supported range of 21 to 400 kHz this keeps each count between 1 and 250. The fast-mode flag is set when the target rate is above 100 kHz.

The block samples the divider word and the fast flag only at the start of each low phase, so reprogramming never shortens or splits a phase already under way. The bit engine uses the reference tick strobe and the one-cycle pulses that mark each falling and rising SCL edge to time its data changes.

Top module: `scl_clock_gen`

## Requirements
- R1: While `enable` is low, `scl_o` is 1, `ref_tick`, `scl_fall` and `scl_rise` are 0, and `fast_o` is 0; this also holds directly after reset.
- R2: While enabled, `ref_tick` pulses once every max(`prescale`,1) clock cycles. The first `scl_fall` pulse appears after the P-th rising clock edge at which `enable` is sampled high, where P is max(`prescale`,1).
- R3: Each low phase of `scl_o`, measured from its `scl_fall` pulse to the next `scl_rise` pulse, lasts max(L,1)*P clock cycles, where L is `divider[7:0]`.
- R4: Each high phase, measured from a `scl_rise` pulse to the next `scl_fall` pulse, lasts max(H,1)*P clock cycles, where H is `divider[15:8]`.
- R5: A prescale, low count or high count of zero behaves exactly like a value of one, so the clock never stalls.
- R6: The block samples `divider` only when a low phase starts. A change made during a high phase leaves that high phase at its old length and takes effect from the next low phase.
- R7: `scl_fall` and `scl_rise` are single-cycle pulses that are never high together. `scl_fall` is high in the first cycle that `scl_o` is 0, and `scl_rise` is high in the first cycle that `scl_o` is 1.
- R8: `fast_o` holds the value `fast_mode` had when the current low phase started, and it changes only together with a `scl_fall` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the clock; low holds counters at zero and SCL high |
| fast_mode | input | 1 | Rate above 100 kHz; sampled at each low-phase start |
| prescale | input | 7 | System clock divisor for the reference tick |
| divider | input | 16 | High count in bits 15:8, low count in bits 7:0 |
| ref_tick | output | 1 | One-cycle strobe at the reference rate |
| scl_o | output | 1 | Serial clock level, 1 when released |
| scl_fall | output | 1 | Pulse in the first cycle SCL is low |
| scl_rise | output | 1 | Pulse in the first cycle SCL is high |
| fast_o | output | 1 | Fast-mode flag latched with the divider |

## Verification
The bench builds the block with its default widths: 7 prescale bits and 8 bits per half count. At these widths the largest prescale of 127 and a low count of 250 both fit within the run, so the longest phases are measured exactly. The same widths make the all-zero codes for prescale and counts reachable, and those runs show that zero is treated as one. A divider and fast-flag change made in the middle of a high phase shows that both values are sampled only at a low-phase start.

// File: rtl/scl_clock_gen.sv
module scl_clock_gen #(
  parameter int PS_W  = 7,
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               fast_mode,
  input  logic [PS_W-1:0]    prescale,
  input  logic [2*CNT_W-1:0] divider,
  output logic               ref_tick,
  output logic               scl_o,
  output logic               scl_fall,
  output logic               scl_rise,
  output logic               fast_o
);

  logic [PS_W-1:0]  ps_cnt, ps_lim;
  logic [CNT_W-1:0] lo_in, hi_in, lo_q, hi_q, div_cnt, cur_lim;
  logic             running, phase_end;

  assign ps_lim   = (prescale == '0) ? PS_W'(1) : prescale;
  assign ref_tick = enable && (ps_cnt >= ps_lim - PS_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !enable || ref_tick) ps_cnt <= '0;
    else                               ps_cnt <= ps_cnt + PS_W'(1);
  end

  assign lo_in     = (divider[CNT_W-1:0] == '0) ? CNT_W'(1) : divider[CNT_W-1:0];
  assign hi_in     = (divider[2*CNT_W-1:CNT_W] == '0) ? CNT_W'(1) : divider[2*CNT_W-1:CNT_W];
  assign cur_lim   = scl_o ? hi_q : lo_q;
  assign phase_end = running && (div_cnt == cur_lim - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      scl_o    <= 1'b1;
      scl_fall <= 1'b0;
      scl_rise <= 1'b0;
      fast_o   <= 1'b0;
      div_cnt  <= '0;
      lo_q     <= CNT_W'(1);
      hi_q     <= CNT_W'(1);
    end else begin
      scl_fall <= 1'b0;
      scl_rise <= 1'b0;
      if (!enable) begin
        running <= 1'b0;
        scl_o   <= 1'b1;
        fast_o  <= 1'b0;
        div_cnt <= '0;
      end else if (ref_tick) begin
        if (!running || (scl_o && phase_end)) begin
          running  <= 1'b1;
          lo_q     <= lo_in;
          hi_q     <= hi_in;
          fast_o   <= fast_mode;
          scl_o    <= 1'b0;
          scl_fall <= 1'b1;
          div_cnt  <= '0;
        end else if (!scl_o && phase_end) begin
          scl_o    <= 1'b1;
          scl_rise <= 1'b1;
          div_cnt  <= '0;
        end else begin
          div_cnt  <= div_cnt + CNT_W'(1);
        end
      end
    end
  end

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (scl_o && !scl_fall && !scl_rise && !fast_o));

  p_tick_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !ref_tick);

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (div_cnt < cur_lim));

  p_fall_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |-> (!scl_o && $past(scl_o)));

  p_rise_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |-> (scl_o && !$past(scl_o)));

  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_fall && scl_rise));

  p_fast_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !scl_fall) |-> $stable(fast_o));

  p_div_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_fall |-> ($stable(lo_q) && $stable(hi_q)));

endmodule

// File: tb/scl_clock_gen_tb.sv
module scl_clock_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        fast_mode = 1'b0;
  logic [6:0]  prescale = 7'd1;
  logic [15:0] divider = 16'h0101;
  logic        ref_tick, scl_o, scl_fall, scl_rise, fast_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  scl_clock_gen u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fast_mode(fast_mode),
    .prescale(prescale), .divider(divider), .ref_tick(ref_tick),
    .scl_o(scl_o), .scl_fall(scl_fall), .scl_rise(scl_rise), .fast_o(fast_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // monitor: measures each phase and compares with the scoreboard queue
  int  mcnt = 0;
  bit  armed = 1'b0;
  bit  exp_low = 1'b1;
  always @(posedge clk) begin
    #2;
    if (!enable) begin
      armed = 1'b0;
      mcnt = 0;
    end else begin
      mcnt++;
      if (scl_fall || scl_rise) begin
        if (armed && exp_q.size() > 0) begin
          automatic int    e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(mcnt == e, t, mcnt, e);
          check(scl_rise == exp_low, "R7 edge order", scl_rise, exp_low);
        end
        check(scl_o == scl_rise && !(scl_fall && scl_rise), "R7 pulse level", scl_o, scl_rise);
        if (!armed) check(scl_fall, "R7 first edge is fall", scl_fall, 1);
        exp_low = scl_fall;
        armed = 1'b1;
        mcnt = 0;
      end
    end
  end

  task automatic wait_empty();
    while (exp_q.size() > 0) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push_periods(input int p, input int l, input int h, input int n, input string tg);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(eff(l) * eff(p)); tag_q.push_back({"R3 low ", tg});
      exp_q.push_back(eff(h) * eff(p)); tag_q.push_back({"R4 high ", tg});
    end
  endtask

  task automatic run_cfg(input int p, input int l, input int h, input int n, input string tg);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    prescale = 7'(p);
    divider = {8'(h), 8'(l)};
    push_periods(p, l, h, n, tg);
    enable = 1'b1;
    wait_empty();
    enable = 1'b0;
  endtask

  task automatic first_fall(input int p);
    int n = 0;
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    prescale = 7'(p);
    enable = 1'b1;
    do begin
      @(posedge clk); #1; n++;
    end while (!scl_fall && n < 400);
    check(n == eff(p), "R2 first fall delay", n, eff(p));
    @(negedge clk);
    enable = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(scl_o == 1'b1, "R1 reset scl", scl_o, 1);
    check(!scl_fall && !scl_rise && !ref_tick && !fast_o, "R1 reset strobes", 1, 0);
    rst_n = 1'b1;
    // R1: disabled for a while, nothing moves
    begin
      int bad = 0;
      for (int i = 0; i < 30; i++) begin
        @(posedge clk); #1;
        if (!scl_o || scl_fall || scl_rise || ref_tick || fast_o) bad++;
      end
      check(bad == 0, "R1 disabled idle", bad, 0);
    end
    // R2: tick rate with prescale 5
    @(negedge clk);
    prescale = 7'd5; divider = 16'h0303; enable = 1'b1;
    begin
      int ticks = 0;
      for (int i = 0; i < 50; i++) begin
        @(posedge clk); #1;
        if (ref_tick) ticks++;
      end
      check(ticks == 10, "R2 tick count", ticks, 10);
    end
    @(negedge clk); enable = 1'b0;
    first_fall(1);
    first_fall(6);
    first_fall(0);  // R5
    run_cfg(1, 3, 2, 3, "p1 l3 h2");
    run_cfg(4, 5, 5, 2, "p4 l5 h5");
    run_cfg(10, 50, 50, 1, "nominal 100kHz");
    run_cfg(3, 250, 5, 2, "max low");
    run_cfg(127, 1, 2, 2, "max prescale");
    run_cfg(0, 0, 0, 3, "R5 zero codes");
    run_cfg(2, 0, 7, 2, "R5 zero low");
    // R6 / R8: change divider and fast flag in the middle of a high phase
    @(negedge clk);
    enable = 1'b0; fast_mode = 1'b0;
    @(negedge clk);
    prescale = 7'd2; divider = 16'h0404;
    exp_q.push_back(8); tag_q.push_back("R6 old low");
    exp_q.push_back(8); tag_q.push_back("R6 old high kept");
    push_periods(2, 2, 2, 2, "R6 new value");
    enable = 1'b1;
    do begin @(posedge clk); #1; end while (!scl_rise);
    @(negedge clk);
    divider = 16'h0202; fast_mode = 1'b1;
    @(posedge clk); #1;
    check(fast_o == 1'b0, "R8 fast held mid-phase", fast_o, 0);
    do begin @(posedge clk); #1; end while (!scl_fall);
    check(fast_o == 1'b1, "R8 fast loaded at fall", fast_o, 1);
    wait_empty();
    enable = 1'b0;
    @(posedge clk); #1;
    check(scl_o == 1'b1 && fast_o == 1'b0, "R1 disable releases", scl_o, 1);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule